// File: doc/BRIEF.md
# Counter and parallel port peripheral

This peripheral sits on a byte-addressed host bus. It combines an eight-pin general-purpose port with a pair of down-counters. Each port pin has its own direction bit and its own bit that selects the port or the interrupt function. The two 16-bit counters run separately or chain into a single 32-bit counter. The low counter, or the chained pair, drives a square-wave output pin. Every register sits at an even byte offset: register n is at offset 2n.

A control bit selects how wide the host data path is. In narrow mode each 16-bit value is split into two byte registers. In wide mode the whole value moves in one access. Changing this bit therefore changes how every later access to the counter registers is interpreted. Reads are combinational from the address. A write takes effect at the next rising clock edge.

Top module: `ctrport_periph`

## Requirements
- R1: After reset the bus is in 8-bit mode and the square-wave output is off (tmr_out low). The mode and counter control registers read 0, both counters are stopped at 0 and the port data latch is 0. Port select and direction registers are all ones, so no pin is driven (gpio_oe = 0).
- R2: A write to an odd byte offset changes no state, and a read from an odd byte offset returns 0.
- R3: Register 16 (offset 32) is mode: bit 0 = 1 selects 16-bit bus mode, and bit 1 = 1 lets the square-wave state reach tmr_out. While bit 1 is 0, tmr_out is low, and the toggle state is kept for when it is set again.
- R4: In 8-bit mode only bus_wdata[7:0] is used. A 16-bit value at register n is reached as its low byte at register n and its high byte at register n+1. A read returns the byte in bits 7:0 with bits 15:8 zero.
- R5: In 16-bit mode a 16-bit value moves whole at register n. Writes to register n+1 are ignored and reads of it return 0.
- R6: Register 19 (offset 38) is port data and drives gpio_out. Register 20 (offset 40) is select and register 21 (offset 42) is direction. A pin is driven (gpio_oe bit 1) exactly when its select bit and its direction bit are both 0.
- R7: A port data read returns gpio_in for pins whose direction bit is 1 and the latched value for pins whose direction bit is 0.
- R8: Register 22 (offset 44) is counter control: bit 0 runs the low counter, bit 1 runs the high counter and bit 2 chains them. A write that sets a run bit that was 0 loads that counter from its start value at that edge. A running counter then steps down by one per clock, and at zero it reloads from its start value.
- R9: A stopped counter holds its value. Registers 28 (offset 56, low) and 30 (offset 60, high) read the live count, and writes to them are ignored. Start values are registers 24 (offset 48, low) and 26 (offset 52, high).
- R10: The square-wave state toggles each time the low counter (split) or the 32-bit counter (chained) reloads at zero. Starting from a load with start value S, the first toggle comes S+1 clocks later, and each toggle after that comes another S+1 clocks later.
- R11: In chained mode the 32-bit count {high, low} is run by bit 0 alone, steps down with a borrow from the high half, and loads both halves when bit 0 rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| gpio_in | input | 8 | External pin levels |
| gpio_out | output | 8 | Latched port data |
| gpio_oe | output | 8 | Per-pin drive enable |
| tmr_out | output | 1 | Square-wave output |

## Verification
The properties assume that a write strobe is held for one cycle with its address and data settled, and that gpio_in changes only away from the rising edge. The bench drives every bus input on the falling edge and keeps each write to a single cycle. It holds gpio_in steady around every port read, so the readback rule can be stated from the direction bits alone. Counter checks start only after a loading write from a stopped state, so the expected count can be computed from a known start.

// File: rtl/ctrport_pkg.sv
package ctrport_pkg;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = ADDR_W - 1;

    typedef logic [IDX_W-1:0] idx_t;

    localparam idx_t IDX_MODE     = 5'd16;
    localparam idx_t IDX_PDATA    = 5'd19;
    localparam idx_t IDX_PSEL     = 5'd20;
    localparam idx_t IDX_PDIR     = 5'd21;
    localparam idx_t IDX_CCTL     = 5'd22;
    localparam idx_t IDX_START_LO = 5'd24;
    localparam idx_t IDX_START_HI = 5'd26;
    localparam idx_t IDX_LIVE_LO  = 5'd28;
    localparam idx_t IDX_LIVE_HI  = 5'd30;

    typedef struct packed {
        logic sqw_en;
        logic bus16;
    } mode_t;

    typedef struct packed {
        logic chain;
        logic run_hi;
        logic run_lo;
    } cctl_t;

    function automatic logic same_pair(input idx_t a, input idx_t b);
        return a[IDX_W-1:1] == b[IDX_W-1:1];
    endfunction

    function automatic logic [HALF_W-1:0] merge_byte(
        input logic [HALF_W-1:0] cur, input logic [BYTE_W-1:0] b, input logic upper);
        logic [HALF_W-1:0] r;
        r = cur;
        if (upper) r[HALF_W-1:BYTE_W] = b;
        else       r[BYTE_W-1:0]      = b;
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] write_half(
        input logic [HALF_W-1:0] cur, input logic [HALF_W-1:0] wd,
        input logic bus16, input logic upper);
        if (bus16) return upper ? cur : wd;
        return merge_byte(cur, wd[BYTE_W-1:0], upper);
    endfunction

    function automatic logic [HALF_W-1:0] view_half(
        input logic [HALF_W-1:0] val, input logic bus16, input logic upper);
        logic [HALF_W-1:0] r;
        r = '0;
        if (bus16) begin
            if (!upper) r = val;
        end else if (upper) begin
            r[BYTE_W-1:0] = val[HALF_W-1:BYTE_W];
        end else begin
            r[BYTE_W-1:0] = val[BYTE_W-1:0];
        end
        return r;
    endfunction
endpackage

// File: rtl/ctrport_regs.sv
module ctrport_regs
    import ctrport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic [HALF_W-1:0] live_lo,
    input  logic [HALF_W-1:0] live_hi,
    input  logic [PORT_W-1:0] port_rd,
    output logic [HALF_W-1:0] rdata,
    output mode_t             mode,
    output cctl_t             cctl,
    output logic              load_lo,
    output logic              load_hi,
    output logic [PORT_W-1:0] pdata,
    output logic [PORT_W-1:0] psel,
    output logic [PORT_W-1:0] pdir,
    output logic [HALF_W-1:0] start_lo,
    output logic [HALF_W-1:0] start_hi
);
    idx_t  idx;
    logic  even_ok;
    logic  wr_ok;
    logic  upper;
    cctl_t cnew;
    logic  rise_lo;
    logic  rise_hi;

    assign idx     = addr[ADDR_W-1:1];
    assign even_ok = ~addr[0];
    assign wr_ok   = wr_en & even_ok;
    assign upper   = idx[0];
    assign cnew    = cctl_t'(wdata[$bits(cctl_t)-1:0]);

    // a run bit going from 0 to 1 loads the counter at the write edge
    assign rise_lo = wr_ok && (idx == IDX_CCTL) && cnew.run_lo && !cctl.run_lo;
    assign rise_hi = wr_ok && (idx == IDX_CCTL) && cnew.run_hi && !cctl.run_hi;
    assign load_lo = rise_lo;
    assign load_hi = cnew.chain ? rise_lo : rise_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            cctl     <= '0;
            pdata    <= '0;
            psel     <= '1;
            pdir     <= '1;
            start_lo <= '0;
            start_hi <= '0;
        end else if (wr_ok) begin
            if (idx == IDX_MODE)  mode  <= mode_t'(wdata[$bits(mode_t)-1:0]);
            if (idx == IDX_PDATA) pdata <= wdata[PORT_W-1:0];
            if (idx == IDX_PSEL)  psel  <= wdata[PORT_W-1:0];
            if (idx == IDX_PDIR)  pdir  <= wdata[PORT_W-1:0];
            if (idx == IDX_CCTL)  cctl  <= cnew;
            if (same_pair(idx, IDX_START_LO))
                start_lo <= write_half(start_lo, wdata, mode.bus16, upper);
            if (same_pair(idx, IDX_START_HI))
                start_hi <= write_half(start_hi, wdata, mode.bus16, upper);
        end
    end

    always_comb begin
        rdata = '0;
        if (even_ok) begin
            if (idx == IDX_MODE)  rdata[$bits(mode_t)-1:0] = mode;
            if (idx == IDX_PDATA) rdata[PORT_W-1:0] = port_rd;
            if (idx == IDX_PSEL)  rdata[PORT_W-1:0] = psel;
            if (idx == IDX_PDIR)  rdata[PORT_W-1:0] = pdir;
            if (idx == IDX_CCTL)  rdata[$bits(cctl_t)-1:0] = cctl;
            if (same_pair(idx, IDX_START_LO)) rdata = view_half(start_lo, mode.bus16, upper);
            if (same_pair(idx, IDX_START_HI)) rdata = view_half(start_hi, mode.bus16, upper);
            if (same_pair(idx, IDX_LIVE_LO))  rdata = view_half(live_lo, mode.bus16, upper);
            if (same_pair(idx, IDX_LIVE_HI))  rdata = view_half(live_hi, mode.bus16, upper);
        end
    end
endmodule

// File: rtl/ctrport_port.sv
module ctrport_port
    import ctrport_pkg::*;
(
    input  logic [PORT_W-1:0] pdata,
    input  logic [PORT_W-1:0] psel,
    input  logic [PORT_W-1:0] pdir,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_rd
);
    assign pin_out = pdata;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        assign pin_oe[i] = ~psel[i] & ~pdir[i];
        assign pin_rd[i] = pdir[i] ? pin_in[i] : pdata[i];
    end
endmodule

// File: rtl/ctrport_counter.sv
module ctrport_counter
    import ctrport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] start_lo,
    input  logic [HALF_W-1:0] start_hi,
    input  cctl_t             cctl,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              sqw_en,
    output logic [HALF_W-1:0] live_lo,
    output logic [HALF_W-1:0] live_hi,
    output logic              tog,
    output logic              cnt_out
);
    localparam int FULL_W = 2 * HALF_W;

    logic [HALF_W-1:0] lo_q, hi_q, lo_d, hi_d;
    logic [FULL_W-1:0] full_q;
    logic              tog_q;
    logic              wrap;

    assign full_q = {hi_q, lo_q};

    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        wrap = 1'b0;
        if (cctl.chain) begin
            if (cctl.run_lo) begin
                if (full_q == '0) begin
                    {hi_d, lo_d} = {start_hi, start_lo};
                    wrap = 1'b1;
                end else begin
                    {hi_d, lo_d} = full_q - FULL_W'(1);
                end
            end
        end else begin
            if (cctl.run_lo) begin
                if (lo_q == '0) begin
                    lo_d = start_lo;
                    wrap = 1'b1;
                end else begin
                    lo_d = lo_q - HALF_W'(1);
                end
            end
            if (cctl.run_hi) begin
                hi_d = (hi_q == '0) ? start_hi : hi_q - HALF_W'(1);
            end
        end
        if (load_lo) lo_d = start_lo;
        if (load_hi) hi_d = start_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= '0;
            hi_q  <= '0;
            tog_q <= 1'b0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
            if (wrap) tog_q <= ~tog_q;
        end
    end

    assign live_lo = lo_q;
    assign live_hi = hi_q;
    assign tog     = tog_q;
    assign cnt_out = sqw_en & tog_q;
endmodule

// File: rtl/ctrport_periph.sv
module ctrport_periph
    import ctrport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] gpio_in,
    output logic [PORT_W-1:0] gpio_out,
    output logic [PORT_W-1:0] gpio_oe,
    output logic              tmr_out
);
    mode_t             mode_q;
    cctl_t             cctl_q;
    logic              load_lo, load_hi;
    logic [PORT_W-1:0] pdata, psel, pdir, port_rd;
    logic [HALF_W-1:0] start_lo, start_hi, live_lo, live_hi;
    logic              tog;

    ctrport_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .live_lo  (live_lo),
        .live_hi  (live_hi),
        .port_rd  (port_rd),
        .rdata    (bus_rdata),
        .mode     (mode_q),
        .cctl     (cctl_q),
        .load_lo  (load_lo),
        .load_hi  (load_hi),
        .pdata    (pdata),
        .psel     (psel),
        .pdir     (pdir),
        .start_lo (start_lo),
        .start_hi (start_hi)
    );

    ctrport_port u_port (
        .pdata   (pdata),
        .psel    (psel),
        .pdir    (pdir),
        .pin_in  (gpio_in),
        .pin_out (gpio_out),
        .pin_oe  (gpio_oe),
        .pin_rd  (port_rd)
    );

    ctrport_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .start_lo (start_lo),
        .start_hi (start_hi),
        .cctl     (cctl_q),
        .load_lo  (load_lo),
        .load_hi  (load_hi),
        .sqw_en   (mode_q.sqw_en),
        .live_lo  (live_lo),
        .live_hi  (live_hi),
        .tog      (tog),
        .cnt_out  (tmr_out)
    );
endmodule

// File: rtl/ctrport_checker.sv
module ctrport_checker
    import ctrport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] wdata_lo,
    input logic [PORT_W-1:0] gpio_out,
    input logic              tmr_out,
    input mode_t             mode_q,
    input cctl_t             cctl_q,
    input logic [HALF_W-1:0] live_lo,
    input logic              load_lo,
    input logic              tog
);
    AST_PDATA_DRIVES_PINS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'd38) |=> (gpio_out == $past(wdata_lo))); // R6

    AST_ODD_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[0]) |=> ($stable(gpio_out) && $stable(mode_q) && $stable(cctl_q))); // R2

    AST_SQW_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'd32 && !wdata_lo[1]) |=> !tmr_out); // R3

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!cctl_q.run_lo && !load_lo) |=> $stable(live_lo)); // R9

    AST_WRAP_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (cctl_q.run_lo && !cctl_q.chain && live_lo == '0) |=> (tog != $past(tog))); // R10
endmodule

bind ctrport_periph ctrport_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wdata_lo (bus_wdata[7:0]),
    .gpio_out (gpio_out),
    .tmr_out  (tmr_out),
    .mode_q   (mode_q),
    .cctl_q   (cctl_q),
    .live_lo  (live_lo),
    .load_lo  (load_lo),
    .tog      (tog)
);

// File: tb/tb_ctrport_periph.sv
module tb_ctrport_periph;
    localparam int CLK_PERIOD = 10;
    localparam int SRC_RD  = 0;
    localparam int SRC_OUT = 1;
    localparam int SRC_OE  = 2;
    localparam int SRC_CNT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  gpio_in = 8'h3C;
    logic [7:0]  gpio_out;
    logic [7:0]  gpio_oe;
    logic        tmr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        int          src;
        logic [15:0] exp;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctrport_periph dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gpio_in   (gpio_in),
        .gpio_out  (gpio_out),
        .gpio_oe   (gpio_oe),
        .tmr_out   (tmr_out)
    );

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = a;
        it.tag = tag; it.src = SRC_RD; it.exp = e;
        sb.push_back(it);
    endtask

    task automatic expect_pin(input int src, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_wr = 1'b0;
        it.tag = tag; it.src = src; it.exp = e;
        sb.push_back(it);
    endtask

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] obs;
                it = sb.pop_front();
                case (it.src)
                    SRC_RD:  obs = bus_rdata;
                    SRC_OUT: obs = {8'h00, gpio_out};
                    SRC_OE:  obs = {8'h00, gpio_oe};
                    default: obs = {15'h0, tmr_out};
                endcase
                checks++;
                if (obs !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_pin(SRC_OE, 16'h0000, "R1 oe");
        expect_pin(SRC_OUT, 16'h0000, "R1 out");
        expect_pin(SRC_CNT, 16'h0000, "R1 tmr");
        expect_rd(6'd32, 16'h0000, "R1 mode");
        expect_rd(6'd44, 16'h0000, "R1 cctl");
        expect_rd(6'd56, 16'h0000, "R1 live");
        expect_rd(6'd38, 16'h003C, "R7 all inputs");

        // R6 / R7 port
        wr(6'd40, 16'h0000);
        wr(6'd42, 16'h00F0);
        wr(6'd38, 16'h0055);
        expect_pin(SRC_OE, 16'h000F, "R6 oe");
        expect_pin(SRC_OUT, 16'h0055, "R6 out");
        expect_rd(6'd38, 16'h0035, "R7 mixed");
        wr(6'd39, 16'h00FF);
        expect_pin(SRC_OUT, 16'h0055, "R2 odd write");
        expect_rd(6'd39, 16'h0000, "R2 odd read");
        wr(6'd40, 16'h0001);
        expect_pin(SRC_OE, 16'h000E, "R6 select");

        // R4 byte access in 8-bit mode
        wr(6'd48, 16'h0003);
        wr(6'd50, 16'h00AB);
        expect_rd(6'd48, 16'h0003, "R4 low byte");
        expect_rd(6'd50, 16'h00AB, "R4 high byte");
        wr(6'd48, 16'hEE03);
        expect_rd(6'd48, 16'h0003, "R4 upper data ignored");
        wr(6'd50, 16'h0000);

        // R8 / R10 split square wave, start 3
        wr(6'd32, 16'h0002);
        wr(6'd44, 16'h0001);
        expect_rd(6'd56, 16'h0003, "R8 load");
        expect_rd(6'd56, 16'h0002, "R8 step");
        expect_pin(SRC_CNT, 16'h0000, "R10 before wrap");
        expect_pin(SRC_CNT, 16'h0000, "R10 at zero");
        expect_pin(SRC_CNT, 16'h0001, "R10 toggle");
        wr(6'd44, 16'h0000);
        expect_rd(6'd56, 16'h0001, "R9 stop");
        expect_pin(SRC_CNT, 16'h0001, "R10 held");
        expect_rd(6'd56, 16'h0001, "R9 hold");
        wr(6'd32, 16'h0000);
        expect_pin(SRC_CNT, 16'h0000, "R3 gated");
        wr(6'd32, 16'h0002);
        expect_pin(SRC_CNT, 16'h0001, "R3 restored");
        wr(6'd56, 16'h00FF);
        expect_rd(6'd56, 16'h0001, "R9 live write ignored");
        expect_rd(6'd58, 16'h0000, "R4 live high byte");

        // R5 16-bit mode
        wr(6'd32, 16'h0003);
        wr(6'd48, 16'h1234);
        expect_rd(6'd48, 16'h1234, "R5 full write");
        wr(6'd50, 16'hFFFF);
        expect_rd(6'd48, 16'h1234, "R5 upper write ignored");
        expect_rd(6'd50, 16'h0000, "R5 upper read");

        // R11 chained counter, start 0x0001_0000
        wr(6'd48, 16'h0000);
        wr(6'd52, 16'h0001);
        wr(6'd44, 16'h0005);
        expect_rd(6'd56, 16'h0000, "R11 load low");
        expect_rd(6'd60, 16'h0000, "R11 borrow high");
        expect_rd(6'd56, 16'hFFFE, "R11 step low");
        wr(6'd52, 16'h0005);
        wr(6'd44, 16'h0002);
        expect_rd(6'd60, 16'h0005, "R8 high load");
        expect_rd(6'd60, 16'h0004, "R8 high step");
        expect_rd(6'd56, 16'hFFFB, "R9 low stopped");

        expect_pin(SRC_OE, 16'h000E, "R6 final");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule